// File: doc/BRIEF.md
# Codec Link Frame Serializer (Controller Side)

This block is the controller end of a five-wire serial audio codec link. The codec supplies the bit clock. The block produces the frame sync, the active-low codec reset and the outgoing serial data. It also deserializes the incoming serial data. Every frame is 256 bit clocks long. It begins with a 16-bit tag slot, and twelve 20-bit data slots follow, all sent MSB first. At nominal rates of 12.288 MHz bit clock and 48 kHz frames, a frame lasts about 21 µs and carries 13 slots.

On the transmit side, the tag and all twelve slots are offered on parallel inputs. They are latched once per frame, at the edge that begins the tag. On the receive side, the same 256-bit layout is collected from the serial input. It is presented on parallel outputs together with a one-bit-clock done strobe.

A four-state machine sequences the link:

| State | Meaning |
|-------|---------|
| HOLD | Reset is asserted. |
| LEAD | Single lead-in cycle after reset release, with sync raised. |
| TAG | Tag bits 0 to 15 are being sent. |
| SLOT | Frame bits 16 to 255 are being sent. |

The transitions are:

- release: HOLD→LEAD, on the first rising edge after reset is released.
- start: LEAD→TAG.
- tag_done: TAG→SLOT, after tag bit 15.
- wrap: SLOT→TAG, after frame bit 255.
- abort: any state→HOLD, asynchronously, whenever reset is asserted.

Top module: `ac97_frame_engine`

## Requirements
- R1: Frame layout. A frame is 256 bits on `ser_out`, one per bit-clock cycle, changing on the rising edge. Frame bit i is word bit 255-i, where the word is {`tx_tag`, `tx_slots`}. Slot k (1..12) occupies `tx_slots[(13-k)*20-1 -: 20]`, so slot 1 is sent first. Frames follow each other without gaps.
- R2: `frm_sync` is high in the last bit cycle (bit 255) of each frame and in tag bits 0 to 14, which is 16 consecutive cycles. It is low everywhere else in the frame.
- R3: `tx_tag` and `tx_slots` are sampled only at the rising edge that starts tag bit 0. Changes later in the frame have no effect on the bits sent.
- R4: `ser_in` is sampled on the falling edge in the middle of each bit cycle. The 256 received bits use the R1 layout in `rx_tag`/`rx_slots`, and these outputs hold until the next frame completes.
- R5: `rx_frame_done` pulses high for exactly one bit-clock period. The pulse starts at the falling edge that samples frame bit 255, together with the update of `rx_tag`/`rx_slots`.
- R6: While `rst_n` is low, `codec_rst_n`, `frm_sync` and `ser_out` are low. This takes effect at once, without waiting for a clock edge.
- R7: At the first rising edge after `rst_n` is released, `codec_rst_n` and `frm_sync` go high while `ser_out` stays low (the lead-in cycle). The next rising edge starts tag bit 0.
- R8: Asserting reset in the middle of a frame aborts that frame. After release, the link restarts exactly as described in R7.
- R9: `rx_frame_done` stays low after reset until a complete 256-bit frame has been received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Bit clock supplied by the codec |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| ser_in | input | 1 | Serial data from the codec |
| tx_tag | input | 16 | Tag slot for the next frame |
| tx_slots | input | 240 | Data slots 1..12 for the next frame (slot 1 in the top bits) |
| frm_sync | output | 1 | Frame sync to the codec |
| ser_out | output | 1 | Serial data to the codec |
| codec_rst_n | output | 1 | Active-low reset to the codec |
| rx_tag | output | 16 | Received tag slot of the last complete frame |
| rx_slots | output | 240 | Received slots 1..12 of the last complete frame |
| rx_frame_done | output | 1 | One-cycle strobe when a received frame completes |

## Verification
The bench targets the following corner cases:

- **Frame wrap.** Sync must already be high in bit 255 of the previous frame. A design that raises sync one cycle late, or holds it for 15 or 17 cycles, shows a wrong sync value at one of these positions.
- **Latch timing of the parallel inputs.** The inputs are inverted in the middle of each frame. A design that samples continuously instead of at the frame boundary sends flipped bits in the second half of the frame.
- **Receive alignment.** A receive path shifted by one bit, or a done strobe that lasts two cycles, shows up in the received word or the strobe value.
- **Reset behaviour.** A reset in the middle of a frame followed by a restart catches a design that keeps its old count, skips the lead-in cycle, or raises a spurious done strobe from a partial frame.

// File: rtl/ac97_link_pkg.sv
package ac97_link_pkg;

    typedef enum logic [1:0] {
        S_HOLD,
        S_LEAD,
        S_TAG,
        S_SLOT
    } link_state_e;

    function automatic int frame_bits(input int tag_w, input int slot_w, input int n_slots);
        return tag_w + slot_w * n_slots;
    endfunction

endpackage

// File: rtl/ac97_frame_seq.sv
module ac97_frame_seq
    import ac97_link_pkg::*;
#(
    parameter int TAG_W     = 16,
    parameter int SLOT_W    = 20,
    parameter int NUM_SLOTS = 12
) (
    input  logic bit_clk,
    input  logic rst_n,
    output logic link_active,
    output logic frame_start,
    output logic last_bit,
    output logic frm_sync,
    output logic codec_rst_n
);
    localparam int FRAME_LEN = frame_bits(TAG_W, SLOT_W, NUM_SLOTS);
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] TAG_END  = CNT_W'(TAG_W - 1);
    localparam logic [CNT_W-1:0] SYNC_END = CNT_W'(TAG_W - 2);

    link_state_e      state_q, state_d;
    logic [CNT_W-1:0] bit_q, bit_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        unique case (state_q)
            S_HOLD: begin
                state_d = S_LEAD;
                bit_d   = '0;
            end
            S_LEAD: begin
                state_d = S_TAG;
                bit_d   = '0;
            end
            S_TAG: begin
                bit_d = bit_q + 1'b1;
                if (bit_q == TAG_END) state_d = S_SLOT;
            end
            S_SLOT: begin
                if (bit_q == LAST_IDX) begin
                    state_d = S_TAG;
                    bit_d   = '0;
                end else begin
                    bit_d = bit_q + 1'b1;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_HOLD;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
        end
    end

    // Outputs
    always_comb begin
        link_active = 1'b0;
        last_bit    = 1'b0;
        frame_start = 1'b0;
        frm_sync    = 1'b0;
        codec_rst_n = 1'b1;
        unique case (state_q)
            S_HOLD: codec_rst_n = 1'b0;
            S_LEAD: begin
                frm_sync    = 1'b1;
                frame_start = 1'b1;
            end
            S_TAG: begin
                link_active = 1'b1;
                frm_sync    = (bit_q <= SYNC_END);
            end
            S_SLOT: begin
                link_active = 1'b1;
                last_bit    = (bit_q == LAST_IDX);
                frm_sync    = (bit_q == LAST_IDX);
                frame_start = (bit_q == LAST_IDX);
            end
        endcase
    end

    p_sync_fall_r2: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $fell(frm_sync) |-> (state_q == S_TAG && bit_q == TAG_END));

    p_wrap_r1: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (state_q == S_SLOT && bit_q == LAST_IDX) |=> (state_q == S_TAG && bit_q == '0));

    p_lead_once_r7: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (state_q == S_LEAD) |=> (state_q == S_TAG));

endmodule

// File: rtl/ac97_tx_serializer.sv
module ac97_tx_serializer #(
    parameter int FRAME_LEN = 256
) (
    input  logic                 bit_clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 active,
    input  logic [FRAME_LEN-1:0] frame_word,
    output logic                 ser_out
);
    logic [FRAME_LEN-1:0] shift_q;

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (load) begin
            shift_q <= frame_word;
        end else if (active) begin
            shift_q <= {shift_q[FRAME_LEN-2:0], 1'b0};
        end
    end

    assign ser_out = active & shift_q[FRAME_LEN-1];

    p_load_msb_r3: assert property (@(posedge bit_clk) disable iff (!rst_n)
        load |=> (ser_out == $past(frame_word[FRAME_LEN-1])));

endmodule

// File: rtl/ac97_rx_deserializer.sv
module ac97_rx_deserializer #(
    parameter int TAG_W     = 16,
    parameter int SLOT_W    = 20,
    parameter int NUM_SLOTS = 12
) (
    input  logic                        bit_clk,
    input  logic                        rst_n,
    input  logic                        active,
    input  logic                        last_bit,
    input  logic                        ser_in,
    output logic [TAG_W-1:0]            rx_tag,
    output logic [SLOT_W*NUM_SLOTS-1:0] rx_slots,
    output logic                        rx_frame_done
);
    localparam int FRAME_LEN = TAG_W + SLOT_W * NUM_SLOTS;

    logic [FRAME_LEN-2:0] shift_q;
    logic [FRAME_LEN-1:0] word_q;

    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q       <= '0;
            word_q        <= '0;
            rx_frame_done <= 1'b0;
        end else begin
            rx_frame_done <= 1'b0;
            if (active) begin
                shift_q <= {shift_q[FRAME_LEN-3:0], ser_in};
                if (last_bit) begin
                    word_q        <= {shift_q, ser_in};
                    rx_frame_done <= 1'b1;
                end
            end
        end
    end

    assign rx_tag   = word_q[FRAME_LEN-1 -: TAG_W];
    assign rx_slots = word_q[SLOT_W*NUM_SLOTS-1:0];

    p_done_single_r5: assert property (@(negedge bit_clk) disable iff (!rst_n)
        rx_frame_done |=> !rx_frame_done);

    p_word_stable_r4: assert property (@(negedge bit_clk) disable iff (!rst_n)
        !rx_frame_done |-> $stable(word_q));

endmodule

// File: rtl/ac97_frame_engine.sv
module ac97_frame_engine
    import ac97_link_pkg::*;
#(
    parameter int TAG_W     = 16,
    parameter int SLOT_W    = 20,
    parameter int NUM_SLOTS = 12
) (
    input  logic                        bit_clk,
    input  logic                        rst_n,
    input  logic                        ser_in,
    input  logic [TAG_W-1:0]            tx_tag,
    input  logic [SLOT_W*NUM_SLOTS-1:0] tx_slots,
    output logic                        frm_sync,
    output logic                        ser_out,
    output logic                        codec_rst_n,
    output logic [TAG_W-1:0]            rx_tag,
    output logic [SLOT_W*NUM_SLOTS-1:0] rx_slots,
    output logic                        rx_frame_done
);
    localparam int FRAME_LEN = frame_bits(TAG_W, SLOT_W, NUM_SLOTS);

    logic link_active;
    logic frame_start;
    logic last_bit;

    ac97_frame_seq #(
        .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)
    ) u_seq (
        .bit_clk     (bit_clk),
        .rst_n       (rst_n),
        .link_active (link_active),
        .frame_start (frame_start),
        .last_bit    (last_bit),
        .frm_sync    (frm_sync),
        .codec_rst_n (codec_rst_n)
    );

    ac97_tx_serializer #(
        .FRAME_LEN(FRAME_LEN)
    ) u_tx (
        .bit_clk    (bit_clk),
        .rst_n      (rst_n),
        .load       (frame_start),
        .active     (link_active),
        .frame_word ({tx_tag, tx_slots}),
        .ser_out    (ser_out)
    );

    ac97_rx_deserializer #(
        .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)
    ) u_rx (
        .bit_clk       (bit_clk),
        .rst_n         (rst_n),
        .active        (link_active),
        .last_bit      (last_bit),
        .ser_in        (ser_in),
        .rx_tag        (rx_tag),
        .rx_slots      (rx_slots),
        .rx_frame_done (rx_frame_done)
    );

    // R6: quiet link while the codec is held in reset
    always @(posedge bit_clk) begin
        if (!codec_rst_n) begin
            p_hold_quiet_r6: assert (!frm_sync && !ser_out);
        end
    end

endmodule

// File: tb/ac97_frame_engine_test.sv
`timescale 1ns/1ps
module ac97_frame_engine_test;
    localparam int TW = 16;
    localparam int SW = 20;
    localparam int NS = 12;
    localparam int FL = TW + SW * NS;

    logic              bit_clk = 1'b0;
    logic              rst_n   = 1'b0;
    logic              ser_in  = 1'b0;
    logic [TW-1:0]     tx_tag  = '0;
    logic [SW*NS-1:0]  tx_slots = '0;
    logic              frm_sync, ser_out, codec_rst_n, rx_frame_done;
    logic [TW-1:0]     rx_tag;
    logic [SW*NS-1:0]  rx_slots;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 bit_clk = ~bit_clk;

    ac97_frame_engine uut (
        .bit_clk(bit_clk), .rst_n(rst_n), .ser_in(ser_in),
        .tx_tag(tx_tag), .tx_slots(tx_slots),
        .frm_sync(frm_sync), .ser_out(ser_out), .codec_rst_n(codec_rst_n),
        .rx_tag(rx_tag), .rx_slots(rx_slots), .rx_frame_done(rx_frame_done)
    );

    function automatic logic [FL-1:0] tx_pat(input int f);
        logic [FL-1:0] w;
        logic [31:0]   v;
        if (f == 0) return '1;
        if (f == 1) return {(FL/2){2'b10}};
        w = '0;
        v = 32'(f) * 32'h0000_4A5B ^ 32'h0000_C3A5;
        w[FL-1 -: TW] = v[TW-1:0];
        for (int k = 1; k <= NS; k++) begin
            v = (32'(f) * 32'h0000_2F1D + 32'(k) * 32'h0009_1B7) ^ (32'(k) << 11);
            w[(NS-k+1)*SW-1 -: SW] = v[SW-1:0];
        end
        return w;
    endfunction

    function automatic logic [FL-1:0] rx_pat(input int f);
        return ~tx_pat(f + 3);
    endfunction

    task automatic check(input string req, input logic [FL-1:0] act, input logic [FL-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge bit_clk);
        #1;
    endtask

    task automatic apply(input logic [FL-1:0] w);
        tx_tag   = w[FL-1 -: TW];
        tx_slots = w[SW*NS-1:0];
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [FL-1:0] cur_tx;
        logic [FL-1:0] cur_rx;
        // R6: reset state, inputs all ones must not leak
        apply('1);
        ser_in = 1'b1;
        repeat (3) tick();
        check("R6 codec_rst_n in reset", FL'(codec_rst_n), '0);
        check("R6 frm_sync in reset", FL'(frm_sync), '0);
        check("R6 ser_out in reset", FL'(ser_out), '0);
        check("R9 done in reset", FL'(rx_frame_done), '0);

        apply(tx_pat(0));
        rst_n = 1'b1;
        tick();
        check("R7 lead sync", FL'(frm_sync), FL'(1));
        check("R7 lead codec_rst_n", FL'(codec_rst_n), FL'(1));
        check("R7 lead ser_out", FL'(ser_out), '0);

        for (int f = 0; f < 5; f++) begin
            cur_tx = tx_pat(f);
            cur_rx = rx_pat(f);
            for (int i = 0; i < FL; i++) begin
                tick();
                check($sformatf("R1 f%0d bit%0d", f, i), FL'(ser_out), FL'(cur_tx[FL-1-i]));
                check($sformatf("R2 f%0d bit%0d", f, i), FL'(frm_sync),
                      FL'((i < TW - 1) || (i == FL - 1)));
                if (i == 0 && f > 0) begin
                    check("R5 done strobe", FL'(rx_frame_done), FL'(1));
                    check("R4 rx word", {rx_tag, rx_slots}, rx_pat(f - 1));
                end else begin
                    check($sformatf("R5 R9 done low f%0d bit%0d", f, i), FL'(rx_frame_done), '0);
                end
                ser_in = cur_rx[FL-1-i];
                if (i == 100) apply(~cur_tx);       // R3: mid-frame change ignored
                if (i == FL - 1) apply(tx_pat(f + 1));
            end
        end

        // R8: abort mid-frame
        repeat (40) tick();
        rst_n = 1'b0;
        #0.2;
        check("R8 R6 async sync low", FL'(frm_sync), '0);
        check("R8 R6 async codec_rst_n low", FL'(codec_rst_n), '0);
        check("R8 R6 async ser_out low", FL'(ser_out), '0);
        tick();
        tick();
        check("R8 held sync", FL'(frm_sync), '0);
        apply(tx_pat(6));
        rst_n = 1'b1;
        tick();
        check("R8 R7 lead sync", FL'(frm_sync), FL'(1));
        check("R8 R7 lead ser_out", FL'(ser_out), '0);
        check("R8 R7 lead codec_rst_n", FL'(codec_rst_n), FL'(1));
        cur_tx = tx_pat(6);
        for (int i = 0; i < FL; i++) begin
            tick();
            check($sformatf("R8 R1 bit%0d", i), FL'(ser_out), FL'(cur_tx[FL-1-i]));
            check($sformatf("R8 R2 bit%0d", i), FL'(frm_sync),
                  FL'((i < TW - 1) || (i == FL - 1)));
            check($sformatf("R9 no done bit%0d", i), FL'(rx_frame_done), '0);
        end
        tick();
        check("R9 done after first full frame", FL'(rx_frame_done), FL'(1));
        finish_run();
    end
endmodule